// File: doc/BRIEF.md
# Low-Power Pseudorandom Scan Pattern Generator

This block produces scan-load stimulus for logic self-test with an adjustable amount of switching. A free-running linear feedback shift register supplies random bits. Each bit passes through its own hold register on the way to a three-input XOR network that feeds the scan chains. A hold register in toggle mode takes its random bit on every clock. In hold mode it keeps its previous value, so the scan chains it feeds see no transitions.

A mode register holds one bit per hold register and picks toggle or hold for each. It is reloaded at every pattern boundary from a serial shift register. That shift register takes in one weighted-random bit per clock. A 4-bit switching code chooses the weight. Each code bit enables one AND term with probability 1/2, 1/4, 1/8 or 1/16, and the enabled terms are ORed together. An all-zero code turns the low-power feature off, and every hold register then toggles.

A two-state controller handles the pattern boundaries. State IDLE waits for the start input. On start it reloads the mode register and moves to state SHIFT. In SHIFT it counts shift cycles and reloads the mode register each time the count wraps. A start seen in SHIFT restarts the pattern. SHIFT stays in SHIFT until reset.

Top module: `lp_prpg`

## Requirements
- R1: Reset is asynchronous and active low. Reset loads the random register with seed 16'hACE1, clears every hold register and the serial shift register to 0, sets every mode bit to 1, and puts the controller in IDLE with its count at 0. The scan outputs therefore read 0 during reset.
- R2: The random register shifts left once on every clock. The new bit 0 is the XOR of the bits selected by mask 16'hB400, which are bits 15, 13, 12 and 10. The register is never zero.
- R3: When its mode bit is 1, or low-power is off, hold register i loads random bit i on every clock.
- R4: When its mode bit is 0 and low-power is on, hold register i keeps its value.
- R5: Weight term k (k = 0..3) is the AND of random bits k(k+1)/2 through k(k+1)/2+k. These are bit 0; bits 1-2; bits 3-5; and bits 6-9.
- R6: The weighted bit is the OR of term k over every k whose switching-code bit k is 1.
- R7: A switching code of 4'b0000 forces every hold register into toggle mode, whatever the mode register holds.
- R8: The serial shift register shifts left on every clock and takes the weighted bit into bit 0. On a reload the mode register copies the serial register's value from before that edge. At all other times the mode register does not change.
- R9: Transitions. IDLE goes to SHIFT on start, with a reload and the count cleared to 0. IDLE with no start stays in IDLE. In SHIFT the count rises by 1 per clock. At count PAT_LEN-1 (15) there is a reload and the count goes to 0. A start in SHIFT reloads at once and clears the count to 0.
- R10: Scan output j (j = 0..7) is the XOR of hold registers j, (j+5) mod 16 and (j+11) mod 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start-of-pattern request |
| sw_code | input | 4 | Switching code; bit k enables weight term k |
| scan_out | output | 8 | Data bits to the scan chains |

## Verification
The bench steps a behavioural model and compares the scan outputs on every clock under several switching codes. The code 4'b1000 leaves most mode bits at 0, so nearly everything holds, and it exposes faults in the hold path and in the 1/16 term. The code 4'b0000 loaded over such a sparse mode register tells the low-power-off override apart from ordinary reloads. The code 4'b0101 exercises the OR merge, and 4'b1111 exercises all four terms together. Starts placed mid-pattern and a reset in mid-run test the restart and wrap timing of the controller and the reset values.

// File: rtl/lp_prpg_pkg.sv
package lp_prpg_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } ctrl_state_t;

    // Index of the phase-shifter tap at chain j, offset off, register width w.
    function automatic int ps_tap(input int j, input int off, input int w);
        return (j + off) % w;
    endfunction

    // First random bit used by weight term k.
    function automatic int wt_base(input int k);
        return (k * (k + 1)) / 2;
    endfunction

endpackage

// File: rtl/lp_prpg_lfsr.sv
module lp_prpg_lfsr #(
    parameter int          W    = 16,
    parameter logic [15:0] MASK = 16'hB400,
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] lfsr_q
);
    localparam logic [W-1:0] MASK_W = MASK[W-1:0];
    localparam logic [W-1:0] SEED_W = SEED[W-1:0];

    logic fb;
    assign fb = ^(lfsr_q & MASK_W);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED_W;
        else        lfsr_q <= {lfsr_q[W-2:0], fb};
    end

    // R2
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
    // R2
    lfsr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> lfsr_q[W-1:1] == $past(lfsr_q[W-2:0]));
endmodule

// File: rtl/lp_prpg_ctrl.sv
module lp_prpg_ctrl
    import lp_prpg_pkg::*;
#(
    parameter int PAT_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic reload
);
    localparam int CW = (PAT_LEN > 2) ? $clog2(PAT_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(PAT_LEN - 1);

    ctrl_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        reload  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_SHIFT;
                    cnt_d   = '0;
                    reload  = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (start || cnt_q == LAST) begin
                    cnt_d  = '0;
                    reload = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R9
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == ST_SHIFT && cnt_q == '0));
    // R9
    idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> state_q == ST_IDLE);
    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && !start && cnt_q != LAST) |=> cnt_q == $past(cnt_q) + 1'b1);
    // R9
    count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && cnt_q == LAST) |=> cnt_q == '0);
endmodule

// File: rtl/lp_prpg_weight.sv
module lp_prpg_weight
    import lp_prpg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lfsr,
    input  logic [3:0]   sw_code,
    input  logic         reload,
    output logic [W-1:0] tcr_q,
    output logic         lp_off
);
    localparam int B3 = wt_base(3);

    logic [3:0]   term;
    logic         wbit;
    logic [W-1:0] sh_q;

    for (genvar k = 0; k < 4; k++) begin : g_term
        localparam int BASE = wt_base(k);
        assign term[k] = &lfsr[BASE +: k + 1];
    end

    assign wbit   = |(term & sw_code);
    assign lp_off = ~|sw_code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            tcr_q <= '1;
        end else begin
            sh_q <= {sh_q[W-2:0], wbit};
            if (reload) tcr_q <= sh_q;
        end
    end

    // R8
    tcr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(tcr_q));
    // R8
    tcr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> tcr_q == $past(sh_q));
    // R8
    sh_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sh_q[W-1:1] == $past(sh_q[W-2:0]));
    // R5
    sparse_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_code == 4'b1000 && !(&lfsr[B3 +: 4])) |=> !sh_q[0]);
endmodule

// File: rtl/lp_prpg_hold.sv
module lp_prpg_hold
    import lp_prpg_pkg::*;
#(
    parameter int W      = 16,
    parameter int CHAINS = 8,
    parameter int OFF1   = 5,
    parameter int OFF2   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      lfsr,
    input  logic [W-1:0]      tcr,
    input  logic              lp_off,
    output logic [CHAINS-1:0] scan_out
);
    logic [W-1:0] lat_q;

    for (genvar i = 0; i < W; i++) begin : g_lat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               lat_q[i] <= 1'b0;
            else if (tcr[i] || lp_off) lat_q[i] <= lfsr[i];
        end

        // R3
        toggle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tcr[i] || lp_off) |=> lat_q[i] == $past(lfsr[i]));
        // R4
        hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!tcr[i] && !lp_off) |=> $stable(lat_q[i]));
    end

    for (genvar j = 0; j < CHAINS; j++) begin : g_ps
        localparam int TA = ps_tap(j, 0, W);
        localparam int TB = ps_tap(j, OFF1, W);
        localparam int TC = ps_tap(j, OFF2, W);
        assign scan_out[j] = lat_q[TA] ^ lat_q[TB] ^ lat_q[TC];
    end
endmodule

// File: rtl/lp_prpg.sv
module lp_prpg #(
    parameter int          W       = 16,
    parameter int          CHAINS  = 8,
    parameter int          PAT_LEN = 16,
    parameter int          OFF1    = 5,
    parameter int          OFF2    = 11,
    parameter logic [15:0] MASK    = 16'hB400,
    parameter logic [15:0] SEED    = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        sw_code,
    output logic [CHAINS-1:0] scan_out
);
    logic [W-1:0] lfsr;
    logic [W-1:0] tcr;
    logic         lp_off;
    logic         reload;

    lp_prpg_lfsr #(.W(W), .MASK(MASK), .SEED(SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .lfsr_q(lfsr)
    );

    lp_prpg_ctrl #(.PAT_LEN(PAT_LEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .reload(reload)
    );

    lp_prpg_weight #(.W(W)) u_weight (
        .clk(clk), .rst_n(rst_n), .lfsr(lfsr), .sw_code(sw_code),
        .reload(reload), .tcr_q(tcr), .lp_off(lp_off)
    );

    lp_prpg_hold #(.W(W), .CHAINS(CHAINS), .OFF1(OFF1), .OFF2(OFF2)) u_hold (
        .clk(clk), .rst_n(rst_n), .lfsr(lfsr), .tcr(tcr),
        .lp_off(lp_off), .scan_out(scan_out)
    );

    // R7
    lp_off_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_code == 4'b0000) |=> scan_out == ($past(lfsr[7:0]) ^ {$past(lfsr[12:5])}
                                              ^ {$past(lfsr[2:0]), $past(lfsr[15:11])}));
endmodule

// File: tb/lp_prpg_tb_top.sv
`timescale 1ns/1ps
module lp_prpg_tb_top;
    localparam int W       = 16;
    localparam int CHAINS  = 8;
    localparam int PAT_LEN = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [3:0]        sw_code = 4'b0000;
    logic [CHAINS-1:0] scan_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    lp_prpg dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .sw_code(sw_code), .scan_out(scan_out)
    );

    // Behavioural reference state
    bit m_lf[W];
    bit m_sh[W];
    bit m_mode[W];
    bit m_hold[W];
    bit m_idle;
    int m_cnt;

    task automatic m_reset();
        bit [15:0] seed = 16'hACE1;          // R1
        for (int i = 0; i < W; i++) begin
            m_lf[i] = seed[i];
            m_sh[i] = 1'b0;
            m_mode[i] = 1'b1;
            m_hold[i] = 1'b0;
        end
        m_idle = 1'b1;
        m_cnt  = 0;
    endtask

    function automatic bit [CHAINS-1:0] m_out();
        bit [CHAINS-1:0] o;
        for (int j = 0; j < CHAINS; j++)     // R10 taps j, j+5, j+11 mod 16
            o[j] = m_hold[j] ^ m_hold[(j + 5) % W] ^ m_hold[(j + 11) % W];
        return o;
    endfunction

    task automatic m_step(input bit st, input bit [3:0] code);
        bit lpoff, wb, rl, fb;
        bit t[4];
        int base;
        lpoff = (code == 4'b0000);                 // R7
        for (int k = 0; k < 4; k++) begin          // R5
            base = k * (k + 1) / 2;
            t[k] = 1'b1;
            for (int b = 0; b <= k; b++) t[k] = t[k] & m_lf[base + b];
        end
        wb = 1'b0;
        for (int k = 0; k < 4; k++) if (code[k]) wb = wb | t[k];   // R6
        if (m_idle) rl = st;                       // R9
        else        rl = st || (m_cnt == PAT_LEN - 1);
        for (int i = 0; i < W; i++)                // R3 / R4
            if (m_mode[i] || lpoff) m_hold[i] = m_lf[i];
        if (rl) for (int i = 0; i < W; i++) m_mode[i] = m_sh[i];   // R8
        for (int i = W - 1; i > 0; i--) m_sh[i] = m_sh[i-1];
        m_sh[0] = wb;
        fb = m_lf[15] ^ m_lf[13] ^ m_lf[12] ^ m_lf[10];            // R2
        for (int i = W - 1; i > 0; i--) m_lf[i] = m_lf[i-1];
        m_lf[0] = fb;
        if (rl)          m_cnt = 0;
        else if (!m_idle) m_cnt = m_cnt + 1;
        if (st) m_idle = 1'b0;
    endtask

    task automatic compare(input string tag);
        bit [CHAINS-1:0] exp;
        exp = m_out();
        n_cmp++;
        if (scan_out !== exp) begin
            n_bad++;
            $display("FAIL %s: scan_out actual %b expected %b at %0t", tag, scan_out, exp, $time);
        end
    endtask

    // One clock: drive inputs after a falling edge, then compare at the next falling edge.
    task automatic cyc(input bit st, input bit [3:0] code, input string tag);
        start   = st;
        sw_code = code;
        if (rst_n) m_step(st, code);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        m_reset();
        @(negedge clk);
        compare("R1 reset outputs");
        @(negedge clk);
        compare("R1 reset outputs");
        rst_n = 1'b1;

        // IDLE with full toggle (mode register reset to ones): R2, R3, R10
        for (int c = 0; c < 20; c++) cyc(1'b0, 4'b0001, "R3 idle toggle/R2/R10");
        // Sparse 1/16 weight, patterns loaded by start and by wrap: R4, R5, R8, R9
        cyc(1'b1, 4'b1000, "R9 start from IDLE");
        for (int c = 0; c < 60; c++) cyc(1'b0, 4'b1000, "R4 hold sparse/R5/R8");
        // Low-power off over a sparse mode register: R7
        for (int c = 0; c < 12; c++) cyc(1'b0, 4'b0000, "R7 code zero forces toggle");
        // OR merge of 1/2 and 1/8 terms: R6
        for (int c = 0; c < 50; c++) cyc(1'b0, 4'b0101, "R6 merged weights");
        // Mid-pattern restarts: R9
        for (int c = 0; c < 5; c++) cyc(1'b0, 4'b1111, "R9 before restart");
        cyc(1'b1, 4'b1111, "R9 restart in SHIFT");
        for (int c = 0; c < 7; c++) cyc(1'b0, 4'b1111, "R9 after restart");
        cyc(1'b1, 4'b0010, "R9 second restart");
        for (int c = 0; c < 40; c++) cyc(1'b0, 4'b0010, "R8 quarter weight/R9 wrap");
        // Reset in mid-run, then IDLE holds until start: R1, R9
        rst_n = 1'b0;
        m_reset();
        @(negedge clk);
        compare("R1 mid-run reset");
        rst_n = 1'b1;
        for (int c = 0; c < 10; c++) cyc(1'b0, 4'b1000, "R9 IDLE waits/R1");
        cyc(1'b1, 4'b1000, "R9 start after reset");
        for (int c = 0; c < 36; c++) cyc(1'b0, 4'b1000, "R4 hold after reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule